// File: doc/BRIEF.md
# Keyed-Access Watchdog Timer

This block is a watchdog timer on a 32-bit register bus. It counts down on a slow tick of about 32 kHz, which arrives as a one-cycle enable on the bus clock. Software sets the timeout and the operating mode by writing registers. Every such write must carry a key pattern, and the block discards any write whose key is wrong. Software keeps the watchdog alive by writing a magic value to a kick register. If the count runs out, the block either drives a reset pulse of configurable polarity or raises a sticky interrupt. A separate keyed register lets software request a reset pulse at once.

The timeout field counts units of 512 slow ticks, so 64 units come to about one second. The 11-bit field holds any timeout from 1 to 31 seconds. Bus reads of the mode and length registers return the stored configuration, and their key fields read as zero.

Top module: `keyed_wdog`

## Requirements
- R1: A write to offset 0x00 whose data bits [31:24] equal 0x22 replaces the mode bits. The bits are: bit 0 run, bit 1 polarity (1 = reset active high), bit 2 reset-output enable, bit 3 interrupt mode, bit 4 auto-start, bit 6 dual. Reading offset 0x00 returns these bits in [6:0], and bit 5 and all higher bits read zero.
- R2: A write to offset 0x04 is accepted only when data bits [4:0] equal 0x08. The timeout in units is then taken from bits [15:5]. Reading offset 0x04 returns the units in [15:5], with all other bits zero.
- R3: An enabled watchdog expires on the slow tick that completes units×512 ticks since the counter was last loaded. It then reloads from the current length.
- R4: Writing exactly 0x1971 to offset 0x08 reloads the counter from the stored length. Any other value written there has no effect.
- R5: An accepted length write also loads the counter with the new timeout.
- R6: While the run bit is clear, the counter holds its value and no expiry occurs.
- R7: On expiry with interrupt mode clear and the reset output enabled, the reset output goes to its active level (high when mode bit 1 is set, low otherwise) on the next clock. It stays there until the fourth slow tick after it started. With the reset output disabled, expiry produces no pulse.
- R8: On expiry with interrupt mode set, the irq output rises and stays high, and no reset pulse is produced. An accepted kick clears irq.
- R9: Writing exactly 0x1209 to offset 0x14 makes the reset output active on the next clock, whatever the mode bits.
- R10: Writes with a wrong key or a wrong magic value to any of the four registers change no state.
- R11: After reset the mode reads 0 and the length reads 1984 units (31 s). The reset output is high, which is the inactive level for active-low polarity, and irq is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | One-cycle slow-clock tick enable |
| wr_en | input | 1 | Register write strobe |
| addr | input | 8 | Byte offset of the register |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for the offset on addr (combinational) |
| rst_out | output | 1 | Watchdog reset output, polarity per mode |
| irq | output | 1 | Sticky expiry interrupt |

## Verification
A write takes effect at the clock edge on which wr_en is sampled. Readback, reset-output activation from a software reset or an expiry, and the rise of irq all become visible one clock after their trigger edge. A reset pulse ends at the fourth tick edge after it started. The bench drives inputs on the falling edge and keeps a behavioural reference model that it advances on each rising edge. One nanosecond after each falling edge it compares rdata, rst_out and irq with the model, so every result is sampled in the cycle it is due. Directed checks add readback values and counts of pulse and interrupt activity over whole scenarios.

// File: rtl/keyed_wdog_pkg.sv
package keyed_wdog_pkg;
  localparam logic [7:0]  OFS_MODE   = 8'h00;
  localparam logic [7:0]  OFS_LEN    = 8'h04;
  localparam logic [7:0]  OFS_KICK   = 8'h08;
  localparam logic [7:0]  OFS_SWRST  = 8'h14;
  localparam logic [7:0]  MODE_KEY   = 8'h22;
  localparam logic [4:0]  LEN_KEY    = 5'h08;
  localparam logic [31:0] KICK_MAGIC = 32'h0000_1971;
  localparam logic [31:0] SWR_MAGIC  = 32'h0000_1209;
  localparam logic [6:0]  MODE_MASK  = 7'h5F;
  localparam int          LEN_LSB    = 5;

  // mode bit positions
  localparam int MB_RUN = 0;
  localparam int MB_POL = 1;
  localparam int MB_EXT = 2;
  localparam int MB_IRQ = 3;

  function automatic logic mode_key_ok(input logic [31:0] d);
    return d[31:24] == MODE_KEY;
  endfunction

  function automatic logic len_key_ok(input logic [31:0] d);
    return d[4:0] == LEN_KEY;
  endfunction
endpackage

// File: rtl/keyed_wdog_regs.sv
module keyed_wdog_regs
  import keyed_wdog_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int LEN_W     = 11,
  parameter int LEN_RESET = 1984
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       wdata,
  output logic [6:0]        mode_q,
  output logic [LEN_W-1:0]  len_q,
  output logic              len_wr_o,
  output logic [LEN_W-1:0]  len_new_o,
  output logic              kick_o,
  output logic              swr_o,
  output logic [31:0]       rdata
);
  logic sel_mode, sel_len, sel_kick, sel_swr, mode_wr;

  assign sel_mode  = wr_en && (addr == ADDR_W'(OFS_MODE));
  assign sel_len   = wr_en && (addr == ADDR_W'(OFS_LEN));
  assign sel_kick  = wr_en && (addr == ADDR_W'(OFS_KICK));
  assign sel_swr   = wr_en && (addr == ADDR_W'(OFS_SWRST));

  assign mode_wr   = sel_mode && mode_key_ok(wdata);
  assign len_wr_o  = sel_len && len_key_ok(wdata);
  assign len_new_o = wdata[LEN_LSB +: LEN_W];
  assign kick_o    = sel_kick && (wdata == KICK_MAGIC);
  assign swr_o     = sel_swr && (wdata == SWR_MAGIC);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= '0;
      len_q  <= LEN_W'(LEN_RESET);
    end else begin
      if (mode_wr)  mode_q <= wdata[6:0] & MODE_MASK;
      if (len_wr_o) len_q  <= len_new_o;
    end
  end

  always_comb begin
    rdata = '0;
    if (addr == ADDR_W'(OFS_MODE))
      rdata[6:0] = mode_q;
    else if (addr == ADDR_W'(OFS_LEN))
      rdata[LEN_LSB +: LEN_W] = len_q;
  end
endmodule

// File: rtl/keyed_wdog_count.sv
module keyed_wdog_count #(
  parameter int LEN_W      = 11,
  parameter int UNIT_TICKS = 512,
  parameter int LEN_RESET  = 1984,
  localparam int CNT_W     = LEN_W + $clog2(UNIT_TICKS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             run,
  input  logic [LEN_W-1:0] len_q,
  input  logic             len_wr,
  input  logic [LEN_W-1:0] len_new,
  input  logic             kick,
  output logic [CNT_W-1:0] cnt_q,
  output logic             expire_o
);
  function automatic logic [CNT_W-1:0] units_to_ticks(input logic [LEN_W-1:0] u);
    return CNT_W'(u) * CNT_W'(UNIT_TICKS);
  endfunction

  logic reload;
  assign reload   = len_wr || kick;
  assign expire_o = !reload && run && tick && (cnt_q <= CNT_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      cnt_q <= units_to_ticks(LEN_W'(LEN_RESET));
    else if (len_wr)
      cnt_q <= units_to_ticks(len_new);
    else if (kick || expire_o)
      cnt_q <= units_to_ticks(len_q);
    else if (run && tick)
      cnt_q <= cnt_q - CNT_W'(1);
  end
endmodule

// File: rtl/keyed_wdog_out.sv
module keyed_wdog_out #(
  parameter int PULSE_TICKS = 4,
  localparam int PC_W       = $clog2(PULSE_TICKS + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic expire,
  input  logic swr,
  input  logic kick,
  input  logic irq_mode,
  input  logic ext_en,
  input  logic pol_high,
  output logic pulse_on,
  output logic rst_out,
  output logic irq
);
  logic [PC_W-1:0] pcnt;
  logic            start;

  assign start    = swr || (expire && !irq_mode && ext_en);
  assign pulse_on = (pcnt != '0);
  assign rst_out  = pulse_on ? pol_high : !pol_high;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pcnt <= '0;
      irq  <= 1'b0;
    end else begin
      if (start)
        pcnt <= PC_W'(PULSE_TICKS);
      else if (tick && pulse_on)
        pcnt <= pcnt - PC_W'(1);

      if (expire && irq_mode)
        irq <= 1'b1;
      else if (kick)
        irq <= 1'b0;
    end
  end
endmodule

// File: rtl/keyed_wdog.sv
module keyed_wdog
  import keyed_wdog_pkg::*;
#(
  parameter int ADDR_W      = 8,
  parameter int LEN_W       = 11,
  parameter int UNIT_TICKS  = 512,
  parameter int LEN_RESET   = 1984,
  parameter int PULSE_TICKS = 4,
  localparam int CNT_W      = LEN_W + $clog2(UNIT_TICKS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       wdata,
  output logic [31:0]       rdata,
  output logic              rst_out,
  output logic              irq
);
  logic [6:0]       mode_q;
  logic [LEN_W-1:0] len_q, len_new_w;
  logic             len_wr_w, kick_w, swr_w, expire_w, reload_w, pulse_on_w;
  logic [CNT_W-1:0] cnt_q;

  assign reload_w = len_wr_w || kick_w;

  keyed_wdog_regs #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .LEN_RESET(LEN_RESET)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .mode_q(mode_q), .len_q(len_q), .len_wr_o(len_wr_w), .len_new_o(len_new_w),
    .kick_o(kick_w), .swr_o(swr_w), .rdata(rdata)
  );

  keyed_wdog_count #(.LEN_W(LEN_W), .UNIT_TICKS(UNIT_TICKS), .LEN_RESET(LEN_RESET)) u_count (
    .clk(clk), .rst_n(rst_n), .tick(tick), .run(mode_q[MB_RUN]), .len_q(len_q),
    .len_wr(len_wr_w), .len_new(len_new_w), .kick(kick_w),
    .cnt_q(cnt_q), .expire_o(expire_w)
  );

  keyed_wdog_out #(.PULSE_TICKS(PULSE_TICKS)) u_out (
    .clk(clk), .rst_n(rst_n), .tick(tick), .expire(expire_w), .swr(swr_w),
    .kick(kick_w), .irq_mode(mode_q[MB_IRQ]), .ext_en(mode_q[MB_EXT]),
    .pol_high(mode_q[MB_POL]), .pulse_on(pulse_on_w), .rst_out(rst_out), .irq(irq)
  );
endmodule

// File: rtl/keyed_wdog_checks.sv
module keyed_wdog_checks #(
  parameter int ADDR_W = 8,
  parameter int LEN_W  = 11,
  parameter int CNT_W  = 20
) (
  input logic              clk,
  input logic              rst_n,
  input logic              tick,
  input logic              wr_en,
  input logic [ADDR_W-1:0] addr,
  input logic [31:0]       wdata,
  input logic [6:0]        mode_q,
  input logic [LEN_W-1:0]  len_q,
  input logic [CNT_W-1:0]  cnt_q,
  input logic              expire,
  input logic              reload,
  input logic              pulse_on,
  input logic              rst_out,
  input logic              irq
);
  AST_SWR_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == ADDR_W'(8'h14) && wdata == 32'h1209) |=> (rst_out == mode_q[1])); // R9
  AST_IRQ_FROM_MODE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(mode_q[3])); // R8
  AST_HOLD_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode_q[0] && !reload) |=> (cnt_q == $past(cnt_q))); // R6
  AST_MODE_BADKEY: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == ADDR_W'(8'h00) && wdata[31:24] != 8'h22) |=> $stable(mode_q)); // R10
  AST_LEN_BADKEY: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == ADDR_W'(8'h04) && wdata[4:0] != 5'h08) |=> $stable(len_q)); // R2
  AST_EXPIRY_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    (expire && !mode_q[3] && mode_q[2]) |=> pulse_on); // R7
  AST_EXPIRY_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    expire |-> (mode_q[0] && tick)); // R3
endmodule

bind keyed_wdog keyed_wdog_checks #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en), .addr(addr), .wdata(wdata),
  .mode_q(mode_q), .len_q(len_q), .cnt_q(cnt_q), .expire(expire_w), .reload(reload_w),
  .pulse_on(pulse_on_w), .rst_out(rst_out), .irq(irq)
);

// File: tb/sim_keyed_wdog.sv
`timescale 1ns/1ps
module sim_keyed_wdog;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b0;
  logic        wr_en = 1'b0;
  logic [7:0]  addr = 8'h00;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        rst_out, irq;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done = 0;

  // behavioural reference state
  logic [6:0] m_mode;
  int         m_len, m_cnt, m_pulse;
  logic       m_irq;
  int         act_cycles, irq_cycles;

  always #2.5 clk = ~clk;

  keyed_wdog u0 (
    .clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .rst_out(rst_out), .irq(irq)
  );

  // slow tick on every second clock
  always @(negedge clk) tick <= ~tick;

  // reference model, advanced once per rising edge
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_mode = 7'h00; m_len = 1984; m_cnt = 1984 * 512; m_pulse = 0; m_irq = 1'b0;
    end else begin
      bit lw, mw, kk, sw, ex;
      lw = wr_en && addr == 8'h04 && wdata[4:0] == 5'h08;
      mw = wr_en && addr == 8'h00 && wdata[31:24] == 8'h22;
      kk = wr_en && addr == 8'h08 && wdata == 32'h1971;
      sw = wr_en && addr == 8'h14 && wdata == 32'h1209;
      ex = 0;
      if (lw) m_cnt = int'(wdata[15:5]) * 512;
      else if (kk) m_cnt = m_len * 512;
      else if (m_mode[0] && tick) begin
        if (m_cnt <= 1) begin ex = 1; m_cnt = m_len * 512; end
        else m_cnt = m_cnt - 1;
      end
      if (sw) m_pulse = 4;
      else if (ex && !m_mode[3] && m_mode[2]) m_pulse = 4;
      else if (tick && m_pulse > 0) m_pulse = m_pulse - 1;
      if (ex && m_mode[3]) m_irq = 1'b1;
      else if (kk) m_irq = 1'b0;
      if (mw) m_mode = wdata[6:0] & 7'h5F;
      if (lw) m_len = int'(wdata[15:5]);
    end
  end

  function automatic logic [31:0] model_rdata(input logic [7:0] a);
    if (a == 8'h00) return {25'd0, m_mode};
    if (a == 8'h04) return 32'(m_len) << 5;
    return 32'd0;
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // continuous comparison, away from the active edge
  always @(negedge clk) begin
    #1;
    if (rst_n && !done) begin
      logic exp_rst;
      exp_rst = (m_pulse > 0) ? m_mode[1] : !m_mode[1];
      check("R7 rst_out vs model", 32'(rst_out), 32'(exp_rst));
      check("R8 irq vs model", 32'(irq), 32'(m_irq));
      check("R1 rdata vs model", rdata, model_rdata(addr));
      if (rst_out == m_mode[1]) act_cycles++;
      if (irq) irq_cycles++;
    end
  end

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0; wdata = '0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic rd(input logic [7:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk);
    addr = a;
    #1;
    check(tag, rdata, exp);
  endtask

  task automatic finish_run();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  // watchdog
  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !done) begin
      errors++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
      finish_run();
    end
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    // R11 reset state
    rd(8'h00, 32'h0, "R11 mode after reset");
    rd(8'h04, 32'd1984 << 5, "R11 length after reset");
    check("R11 rst_out idle", 32'(rst_out), 32'd1);
    check("R11 irq idle", 32'(irq), 32'd0);

    // R10 wrong keys and magic values
    wr(8'h00, 32'h1100_0007);
    wr(8'h04, 32'h0000_0029);
    wr(8'h08, 32'h0000_1972);
    wr(8'h14, 32'h0000_1208);
    idle(2);
    rd(8'h00, 32'h0, "R10 mode unchanged by bad key");
    rd(8'h04, 32'd1984 << 5, "R10 length unchanged by bad key");
    check("R10 no pulse from bad magic", 32'(rst_out), 32'd1);

    // R1 readback masks bit 5
    wr(8'h00, 32'h2200_00FF);
    rd(8'h00, 32'h5F, "R1 mode readback");
    wr(8'h00, 32'h2200_0000);

    // R2 length field
    wr(8'h04, 32'h0000_0028);
    rd(8'h04, 32'h20, "R2 length readback");

    // R3/R7 expiry with active-high pulse
    wr(8'h00, 32'h2200_0007);
    act_cycles = 0;
    idle(1200);
    check("R3 expiry produced pulse", 32'(act_cycles > 0), 32'd1);
    check("R7 pulse spans 4 ticks", 32'(act_cycles >= 6 && act_cycles <= 8), 32'd1);

    // R4 periodic kicks prevent expiry
    wr(8'h08, 32'h0000_1971);
    act_cycles = 0;
    for (int i = 0; i < 6; i++) begin
      idle(400);
      wr(8'h08, 32'h0000_1971);
    end
    check("R4 kicks keep reset idle", 32'(act_cycles), 32'd0);

    // R5 length write reloads
    act_cycles = 0;
    idle(700);
    wr(8'h04, 32'h0000_0028);
    idle(700);
    check("R5 length write reloaded", 32'(act_cycles), 32'd0);

    // R6 disabled holds
    wr(8'h00, 32'h2200_0006);
    act_cycles = 0;
    idle(3000);
    check("R6 no expiry while stopped", 32'(act_cycles), 32'd0);

    // R7 reset output disabled, active-low polarity
    wr(8'h00, 32'h2200_0001);
    act_cycles = 0;
    idle(2200);
    check("R7 no pulse with output disabled", 32'(act_cycles), 32'd0);

    // R8 interrupt mode
    wr(8'h08, 32'h0000_1971);
    wr(8'h00, 32'h2200_000D);
    act_cycles = 0; irq_cycles = 0;
    idle(1200);
    check("R8 irq raised", 32'(irq), 32'd1);
    check("R8 no pulse in irq mode", 32'(act_cycles), 32'd0);
    wr(8'h08, 32'h0000_1971);
    #1;
    check("R8 kick clears irq", 32'(irq), 32'd0);

    // R9 software reset while stopped, active-low
    wr(8'h00, 32'h2200_0000);
    @(negedge clk);
    wr_en = 1'b1; addr = 8'h14; wdata = 32'h0000_1209;
    @(negedge clk);
    wr_en = 1'b0; wdata = '0;
    #1;
    check("R9 software reset active next cycle", 32'(rst_out), 32'd0);
    idle(20);
    check("R9 software reset ends", 32'(rst_out), 32'd1);

    idle(5);
    finish_run();
  end
endmodule